// File: doc/BRIEF.md
# Two-Channel Interrupt Collector with Halt and Reset Handshake

This block gathers the events of a controller that drives two serial-bus master channels, each with two command queues, into a single 32-bit sticky status word and one interrupt line. Events come in as single-cycle pulses: read done, queue report, acknowledge failure and other bus errors. Each event sets its own status bit. A mask register selects which bits drive the registered interrupt output. Software clears bits by writing ones to a clear register. A global-clear strobe drops the interrupt line for one cycle.

Error recovery follows a fixed sequence. Software writes a halt request for the failing channel, which stops that channel's queues and raises a halt-acknowledge bit. Software then writes a reset command. After a fixed latency the block reports completion on a reset-done bit, and at the same moment it releases the halt on every channel that was reset. The serial engines are outside the block. They are represented by the event inputs and by the halt and reset outputs.

Register access uses a single-cycle write port and a combinational read port with word addresses. Address 0 is status (read only), 1 is mask (read/write), 2 is clear, 3 is global clear, 4 is halt (writes request a halt; reads return the halt state in bits 1:0), and 5 is the reset command.

Top module: `chirq_top`

## Requirements
- R1: After reset the status word reads 0 at address 0, and irq_o, halt_o and chan_rst_o are all 0.
- R2: A pulse on an event input sets its status bit, and the bit can be read after the next clock edge. The bit stays set until it is cleared. For channel c (c = 0, 1) the bit positions are: read done at bit 12c, queue 0 report at bit 12c+4, and queue 1 report at bit 12c+8.
- R3: Each channel has eight non-acknowledge bus-error inputs, bus_err_i[8c+k] for k = 0..7. They map to bits 12c + {1,2,5,6,7,9,10,11}. Acknowledge failures nack_i[2c+q] map to bit 27+2c+q. All errors of channel 0 together form 0x18000EE6, and all errors of channel 1 form 0x60EE6000.
- R4: Writing to address 2 clears every status bit written as 1 and leaves the bits written as 0 unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R5: irq_o is a register that holds the OR of (status AND mask). It rises one edge after a masked bit is set, or one edge after the mask is written to cover a bit that is already pending. It falls one edge after the last pending masked bit is cleared.
- R6: A write to address 3 with bit 0 set forces irq_o to 0 for one cycle and leaves the status unchanged. If masked bits are still pending, irq_o returns on the following edge. A write to address 3 with bit 0 clear has no effect.
- R7: Writing bit c of address 4 sets halt_o[c] after that edge. Status bit 25+c is set one edge later. A halt request to a channel that is already halted produces no new acknowledge.
- R8: A write to address 5 selects channel c when every bit of that channel's mask is present in the data. The mask is 0x3F1 for channel 0 and 0x3F001 for channel 1, and the whole-controller value 0x0F73F3F7 selects both. The selected chan_rst_o bits are high for 4 cycles after the write edge. Status bit 24 is set 4 edges after the write edge. On that same edge halt_o of the selected channels clears.
- R9: A reset command that contains neither channel mask in full starts nothing. chan_rst_o stays 0 and bit 24 is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| rd_done_i | input | 2 | Read-done pulse per channel |
| q_report_i | input | 4 | Queue report pulse, index 2c+q |
| nack_i | input | 4 | Acknowledge-failure pulse, index 2c+q |
| bus_err_i | input | 16 | Other bus-error pulses, index 8c+k |
| irq_o | output | 1 | Registered interrupt line |
| halt_o | output | 2 | Queue halt per channel |
| chan_rst_o | output | 2 | Channel reset in progress |

## Verification
The bench pulses each event source one at a time and checks that exactly one status bit appears at the computed position. A swapped or shifted error position would set the wrong bit, or would break the two error-group totals. It writes the clear register in the same cycle as an event on the same bit: a design that let the clear win would read back zero. It strikes the global clear while a masked bit is pending and checks that irq_o falls for exactly one cycle and then returns. A design that cleared status, or that left the line low, would fail here. Reset commands are tracked cycle by cycle. Reset-done must not appear before the fourth edge, partial masks must start nothing, and halts must be released only on the channels that were reset.

// File: rtl/chirq_pkg.sv
package chirq_pkg;
  localparam int NCH       = 2;
  localparam int NQ        = 2;
  localparam int DW        = 32;
  localparam int AW        = 3;
  localparam int ERR_N     = 8;
  localparam int CH_STRIDE = 12;
  localparam int B_QREP    = 4;
  localparam int B_RSTDONE = 24;
  localparam int B_HALTACK = 25;
  localparam int B_NACK    = 27;

  typedef enum logic [AW-1:0] {
    A_STAT = 3'd0,
    A_MASK = 3'd1,
    A_CLR  = 3'd2,
    A_GCLR = 3'd3,
    A_HALT = 3'd4,
    A_RST  = 3'd5
  } reg_addr_e;

  // bit offset inside a channel slice for non-nack error k
  function automatic int err_pos(input int k);
    if (k < 2)      return k + 1;
    else if (k < 5) return k + 3;
    else            return k + 4;
  endfunction

  function automatic logic [DW-1:0] chan_rst_mask(input int c);
    return (c == 0) ? 32'h0000_03F1 : 32'h0003_F001;
  endfunction
endpackage

// File: rtl/chirq_status_bank.sv
module chirq_status_bank #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  input  logic [DW-1:0] mask_i,
  input  logic          gclr_i,
  output logic [DW-1:0] status_o,
  output logic          irq_o
);
  logic [DW-1:0] status_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;  // event beats clear
      irq_q    <= gclr_i ? 1'b0 : |(status_q & mask_i);
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(set_i)) == $past(set_i)));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((status_q & $past(clr_i & ~set_i)) == '0));
  assert_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gclr_i && ((status_q & mask_i) != '0)) |=> irq_q);
  assert_gclr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gclr_i |=> !irq_q);
endmodule

// File: rtl/chirq_halt_unit.sv
module chirq_halt_unit #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] rel_i,
  output logic [NCH-1:0] halt_o,
  output logic [NCH-1:0] ack_o
);
  logic [NCH-1:0] halt_q, halt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= '0;
      halt_d <= '0;
    end else begin
      halt_q <= (halt_q & ~rel_i) | req_i;
      halt_d <= halt_q;
    end
  end

  assign halt_o = halt_q;
  assign ack_o  = halt_q & ~halt_d;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_halt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt_q[c] && !rel_i[c]) |=> halt_q[c]);
    assert_halt_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[c] |=> halt_q[c]);
  end
endmodule

// File: rtl/chirq_reset_seq.sv
module chirq_reset_seq
  import chirq_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_we_i,
  input  logic [DW-1:0]  cmd_i,
  output logic [NCH-1:0] busy_o,
  output logic [NCH-1:0] rel_o,
  output logic           done_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [NCH-1:0] sel;
  logic [NCH-1:0] chans_q;
  logic [CW-1:0]  cnt_q;
  logic           hit;

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign sel[c] = (cmd_i & chan_rst_mask(c)) == chan_rst_mask(c);
  end

  assign hit    = cmd_we_i && (|sel);
  assign done_o = (cnt_q == CW'(1)) && !hit;
  assign rel_o  = chans_q & {NCH{done_o}};
  assign busy_o = chans_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      chans_q <= '0;
    end else if (hit) begin
      cnt_q   <= CW'(LAT);
      chans_q <= chans_q | sel;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) chans_q <= '0;
    end
  end

  assert_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (busy_o == '0));
  assert_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && (sel == '0) && (cnt_q == '0)) |=> (busy_o == '0) && (cnt_q == '0));
endmodule

// File: rtl/chirq_top.sv
module chirq_top
  import chirq_pkg::*;
#(
  parameter int RST_LAT = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  input  logic [NCH-1:0]       rd_done_i,
  input  logic [NCH*NQ-1:0]    q_report_i,
  input  logic [NCH*NQ-1:0]    nack_i,
  input  logic [NCH*ERR_N-1:0] bus_err_i,
  output logic                 irq_o,
  output logic [NCH-1:0]       halt_o,
  output logic [NCH-1:0]       chan_rst_o
);
  logic [DW-1:0]  mask_q, set_v, clr_v, status;
  logic           gclr;
  logic [NCH-1:0] halt_req, halt_ack, halt_rel;
  logic           rst_done;

  assign clr_v    = (reg_we_i && reg_addr_i == A_CLR) ? reg_wdata_i : '0;
  assign gclr     = reg_we_i && reg_addr_i == A_GCLR && reg_wdata_i[0];
  assign halt_req = (reg_we_i && reg_addr_i == A_HALT) ? reg_wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (reg_we_i && reg_addr_i == A_MASK) mask_q <= reg_wdata_i;
  end

  always_comb begin
    set_v = '0;
    for (int c = 0; c < NCH; c++) begin
      set_v[c*CH_STRIDE] = rd_done_i[c];
      for (int q = 0; q < NQ; q++) begin
        set_v[c*CH_STRIDE + B_QREP*(q+1)] = q_report_i[c*NQ+q];
        set_v[B_NACK + c*NQ + q]          = nack_i[c*NQ+q];
      end
      for (int k = 0; k < ERR_N; k++)
        set_v[c*CH_STRIDE + err_pos(k)] = bus_err_i[c*ERR_N+k];
      set_v[B_HALTACK + c] = halt_ack[c];
    end
    set_v[B_RSTDONE] = rst_done;
  end

  chirq_status_bank #(.DW(DW)) u_bank (
    .clk_i, .rst_ni,
    .set_i(set_v), .clr_i(clr_v), .mask_i(mask_q), .gclr_i(gclr),
    .status_o(status), .irq_o(irq_o)
  );

  chirq_halt_unit #(.NCH(NCH)) u_halt (
    .clk_i, .rst_ni,
    .req_i(halt_req), .rel_i(halt_rel), .halt_o(halt_o), .ack_o(halt_ack)
  );

  chirq_reset_seq #(.LAT(RST_LAT)) u_rst (
    .clk_i, .rst_ni,
    .cmd_we_i(reg_we_i && reg_addr_i == A_RST), .cmd_i(reg_wdata_i),
    .busy_o(chan_rst_o), .rel_o(halt_rel), .done_o(rst_done)
  );

  always_comb begin
    case (reg_addr_i)
      A_STAT:  reg_rdata_o = status;
      A_MASK:  reg_rdata_o = mask_q;
      A_HALT:  reg_rdata_o = DW'(halt_o);
      default: reg_rdata_o = '0;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_top_chk
    assert_halt_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halt_ack[c] |=> status[B_HALTACK + c]);
    assert_halt_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt_rel[c] && !halt_req[c]) |=> !halt_o[c]);
  end
  assert_rst_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_done |=> status[B_RSTDONE]);
  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (status == '0) && !irq_o && (halt_o == '0) && (chan_rst_o == '0));
endmodule

// File: tb/sim_chirq_top.sv
module sim_chirq_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [1:0]  rd_done_i = '0;
  logic [3:0]  q_report_i = '0;
  logic [3:0]  nack_i = '0;
  logic [15:0] bus_err_i = '0;
  logic        irq_o;
  logic [1:0]  halt_o, chan_rst_o;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  chirq_top u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  function automatic bit is_src(input int b);
    if (b == 24 || b == 25 || b == 26 || b > 30) return 0;
    if (b < 24 && (b % 12) == 3) return 0;
    return 1;
  endfunction

  task automatic drive_bit(input int b);
    int c, w, k;
    if (b >= 27) nack_i[b-27] = 1'b1;
    else begin
      c = b / 12; w = b % 12;
      if (w == 0) rd_done_i[c] = 1'b1;
      else if (w == 4) q_report_i[2*c] = 1'b1;
      else if (w == 8) q_report_i[2*c+1] = 1'b1;
      else begin
        k = (w < 3) ? w - 1 : (w < 8) ? w - 3 : w - 4;
        bus_err_i[8*c+k] = 1'b1;
      end
    end
  endtask

  task automatic release_all();
    rd_done_i = '0; q_report_i = '0; nack_i = '0; bus_err_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    peek(3'd0, d); chk("R1 status", d, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 halt", {30'd0, halt_o}, 0);
    chk("R1 chan_rst", {30'd0, chan_rst_o}, 0);

    // R2 R3 R4 R5 sweep over every source bit
    for (int b = 0; b < 31; b++) begin
      if (is_src(b)) begin
        drive_bit(b);
        @(negedge clk_i);
        release_all();
        peek(3'd0, d); chk(b >= 27 || (b%12 != 0 && b%12 != 4 && b%12 != 8) ? "R3 error bit" : "R2 event bit", d, 32'd1 << b);
        @(negedge clk_i);
        peek(3'd0, d); chk("R2 sticky", d, 32'd1 << b);
        chk("R5 unmasked irq low", {31'd0, irq_o}, 0);
        wr(3'd1, 32'd1 << b);
        chk("R5 irq not yet", {31'd0, irq_o}, 0);
        @(negedge clk_i);
        chk("R5 irq raised", {31'd0, irq_o}, 1);
        wr(3'd2, ~(32'd1 << b));
        peek(3'd0, d); chk("R4 zero bits untouched", d, 32'd1 << b);
        wr(3'd2, 32'd1 << b);
        peek(3'd0, d); chk("R4 cleared", d, 0);
        @(negedge clk_i);
        chk("R5 irq falls", {31'd0, irq_o}, 0);
        wr(3'd1, 0);
      end
    end

    // R3 groups
    nack_i = 4'b0011; bus_err_i = 16'h00FF;
    @(negedge clk_i); release_all();
    peek(3'd0, d); chk("R3 ch0 group", d, 32'h18000EE6);
    wr(3'd2, 32'hFFFF_FFFF);
    nack_i = 4'b1100; bus_err_i = 16'hFF00;
    @(negedge clk_i); release_all();
    peek(3'd0, d); chk("R3 ch1 group", d, 32'h60EE6000);
    wr(3'd2, 32'hFFFF_FFFF);
    rd_done_i = 2'b11; q_report_i = 4'hF;
    @(negedge clk_i); release_all();
    peek(3'd0, d); chk("R2 all events", d, 32'h0011_1111);
    wr(3'd2, 32'hFFFF_FFFF);

    // R4 event beats clear
    rd_done_i[0] = 1'b1; q_report_i[0] = 1'b1;
    @(negedge clk_i); release_all();
    rd_done_i[0] = 1'b1;
    wr(3'd2, 32'h11);
    release_all();
    peek(3'd0, d); chk("R4 event wins", d, 32'h1);

    // R6 global clear
    wr(3'd1, 32'h1);
    @(negedge clk_i);
    chk("R6 irq pending", {31'd0, irq_o}, 1);
    wr(3'd3, 32'h2);
    chk("R6 bit0 clear no effect", {31'd0, irq_o}, 1);
    wr(3'd3, 32'h1);
    chk("R6 irq dropped", {31'd0, irq_o}, 0);
    peek(3'd0, d); chk("R6 status kept", d, 32'h1);
    @(negedge clk_i);
    chk("R6 irq returns", {31'd0, irq_o}, 1);
    wr(3'd1, 0);
    wr(3'd2, 32'hFFFF_FFFF);

    // R7 halt
    wr(3'd4, 32'h1);
    chk("R7 halt ch0", {30'd0, halt_o}, 32'h1);
    peek(3'd0, d); chk("R7 ack not yet", d, 0);
    @(negedge clk_i);
    peek(3'd0, d); chk("R7 ack ch0", d, 32'h1 << 25);
    peek(3'd4, d); chk("R7 halt readback", d, 32'h1);
    wr(3'd2, 32'h1 << 25);
    wr(3'd4, 32'h1);
    repeat (2) @(negedge clk_i);
    peek(3'd0, d); chk("R7 no repeat ack", d, 0);
    wr(3'd4, 32'h2);
    chk("R7 halt both", {30'd0, halt_o}, 32'h3);
    @(negedge clk_i);
    peek(3'd0, d); chk("R7 ack ch1", d, 32'h1 << 26);
    wr(3'd2, 32'hFFFF_FFFF);

    // R8 channel 0 reset
    wr(3'd5, 32'h0000_03F1);
    chk("R8 ch0 rst", {30'd0, chan_rst_o}, 32'h1);
    for (int j = 1; j <= 3; j++) begin
      @(negedge clk_i);
      peek(3'd0, d); chk("R8 done early", d, 0);
      chk("R8 rst held", {30'd0, chan_rst_o}, 32'h1);
    end
    @(negedge clk_i);
    peek(3'd0, d); chk("R8 done at 4", d, 32'h1 << 24);
    chk("R8 rst ends", {30'd0, chan_rst_o}, 0);
    chk("R8 ch0 released", {30'd0, halt_o}, 32'h2);
    wr(3'd2, 32'hFFFF_FFFF);

    // R8 full reset
    wr(3'd4, 32'h1);
    wr(3'd5, 32'h0F73_F3F7);
    chk("R8 full rst", {30'd0, chan_rst_o}, 32'h3);
    repeat (4) @(negedge clk_i);
    chk("R8 full released", {30'd0, halt_o}, 0);
    peek(3'd0, d); chk("R8 full done", d & (32'h1 << 24), 32'h1 << 24);
    wr(3'd2, 32'hFFFF_FFFF);

    // R8 channel 1 reset
    wr(3'd5, 32'h0003_F001);
    chk("R8 ch1 rst", {30'd0, chan_rst_o}, 32'h2);
    repeat (4) @(negedge clk_i);
    peek(3'd0, d); chk("R8 ch1 done", d, 32'h1 << 24);
    wr(3'd2, 32'hFFFF_FFFF);

    // R9 incomplete masks
    wr(3'd5, 32'h0000_03F0);
    chk("R9 partial ch0", {30'd0, chan_rst_o}, 0);
    wr(3'd5, 32'h0003_E001);
    chk("R9 partial ch1", {30'd0, chan_rst_o}, 0);
    wr(3'd5, 32'h0);
    repeat (6) @(negedge clk_i);
    peek(3'd0, d); chk("R9 no done", d, 0);
    chk("R9 no rst", {30'd0, chan_rst_o}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule